// File: doc/BRIEF.md
# Channel Datapath Self-Test Engine

This block checks a filter channel's datapath by driving a known stimulus into the channel input and folding the channel's output samples into two compact signatures. The stimulus comes from one of three sources: vectors supplied from outside, a 23-bit maximal-length pseudorandom sequence, or a full-scale sine built from a quarter-wave table. The in-phase and quadrature outputs each feed their own 16-bit multiple-input signature register (MISR), so a fault on one path leaves the other signature intact.

A run is set up with an arm pulse while the channel is asleep. The arm pulse latches the run length and the source select, clears both signatures and rewinds the generators. A later sync pulse starts the run. While the run is active, every output-valid sample from the channel updates both signatures and reduces the remaining count by one. When the count reaches zero the done flag rises and the signatures stay fixed until the next arm, so software can compare them against known-good values.

Top module: `chan_sigbist`

## Requirements
- R1: An arm latches `run_len` as the number of channel output samples to observe. The run then ends after exactly that many output-valid samples taken while running.
- R2: The source select is latched at arm. `mode_sel[1]`=1 picks the pseudorandom source, whatever `mode_sel[0]` is. `mode_sel`=01 picks the sine. `mode_sel`=00 passes `ext_i`/`ext_q` straight through to `stim_i`/`stim_q`.
- R3: The pseudorandom source is a 23-bit Fibonacci LFSR with polynomial x^23+x^18+1, bit 0 being the new bit = bit22 XOR bit17. It is set to all ones at arm and shifts once per running cycle. `stim_i` = lfsr[15:0] and `stim_q` = lfsr[22:7].
- R4: The sine has a 64-sample period. Its phase is 0 at arm and advances by one per running cycle. `stim_i` = round(32767·sin(2πp/64)) and `stim_q` is the same expression at phase p+16 (mod 64).
- R5: `stim_i` and `stim_q` are zero whenever no run is active.
- R6: An arm is accepted only while `sleep_in` is high, and an accepted arm clears both signatures to zero. An arm with `sleep_in` low changes nothing.
- R7: A sync pulse starts the run only when the block is armed. A sync in any other state has no effect.
- R8: Each output-valid sample in a run updates each signature independently: sig ← {sig[14:0],0} XOR (sig[15] ? 0x100B : 0) XOR data. The I signature takes `chan_i` and the Q signature takes `chan_q`.
- R9: `done` rises when the count reaches zero. After that `done`, `sig_i` and `sig_q` hold, and output-valid samples are ignored, until the next accepted arm.
- R10: If the latched count is zero, a sync goes straight to done without sampling.
- R11: An accepted arm takes priority over everything else in the same cycle, including the last counted sample of a run.
- R12: `busy` is high exactly while a run is active, and `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_in | input | 1 | Channel is asleep; an arm is accepted only while this is high |
| arm_in | input | 1 | Arm pulse: latch settings, clear signatures |
| sync_in | input | 1 | Sync pulse that starts an armed run |
| run_len | input | 20 | Number of channel outputs to observe |
| mode_sel | input | 2 | Source select: [1] pseudorandom, [0] sine |
| ext_i | input | 16 | External I test vector |
| ext_q | input | 16 | External Q test vector |
| stim_i | output | 16 | Stimulus to channel, I |
| stim_q | output | 16 | Stimulus to channel, Q |
| chan_valid | input | 1 | Channel output sample valid |
| chan_i | input | 16 | Channel output, I |
| chan_q | input | 16 | Channel output, Q |
| sig_i | output | 16 | I signature |
| sig_q | output | 16 | Q signature |
| busy | output | 1 | Run active |
| done | output | 1 | Run complete |

## Verification
Two functions can land on the same clock edge: an accepted arm and the output-valid sample that would bring the count to zero. The bench watches its reference model and raises the arm on exactly the cycle where one count remains and the delayed channel valid is high. It then expects `done` low, both signatures zero and no run active. A sync that arrives during a run or after done is also applied, and must leave the run's outcome unchanged.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int SAMPLE_W = 16;
  localparam int PHASE_W  = 6;
  localparam int LFSR_W   = 23;
  localparam int LFSR_TAP = 18;
  localparam int COUNT_W  = 20;
  localparam int LANES    = 2;
  localparam logic [SAMPLE_W-1:0] SIG_POLY = 16'h100B;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } bist_st_e;
endpackage

// File: rtl/bist_ctrl.sv
module bist_ctrl
  import bist_pkg::*;
#(
  parameter int CW = COUNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_ok,
  input  logic          sync,
  input  logic          valid,
  input  logic [CW-1:0] cnt_init,
  output logic          running,
  output logic          done,
  output logic          upd
);
  bist_st_e      st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign running = (st_q == ST_RUN);
  assign done    = (st_q == ST_DONE);
  // an accepted arm overrides the sample in the same cycle
  assign upd     = running & valid & ~arm_ok;
  assign cnt_en  = arm_ok | upd;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (arm_ok) begin
      st_d  = ST_ARMED;
      cnt_d = cnt_init;
    end else begin
      case (st_q)
        ST_ARMED: if (sync) st_d = (cnt_q == '0) ? ST_DONE : ST_RUN;
        ST_RUN: if (valid) begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == CW'(1)) st_d = ST_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  a_r12_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(running && done));
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm_ok) |=> done);
  a_r10_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && sync && !arm_ok && cnt_q == '0) |=> done);
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r6_arm_loads: assert property (@(posedge clk) disable iff (!rst_n)
    arm_ok |=> (st_q == ST_ARMED && cnt_q == $past(cnt_init)));
endmodule

// File: rtl/bist_misr.sv
module bist_misr
  import bist_pkg::*;
#(
  parameter int             W    = SAMPLE_W,
  parameter logic [W-1:0]   POLY = SIG_POLY
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         upd,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);
  logic [W-1:0] sig_q, sig_d;
  logic         sig_en;

  assign sig_en = clr | upd;

  always_comb begin
    sig_d = sig_q;
    if (clr)      sig_d = '0;
    else if (upd) sig_d = {sig_q[W-2:0], 1'b0} ^ (sig_q[W-1] ? POLY : '0) ^ din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sig_q <= '0;
    else if (sig_en) sig_q <= sig_d;
  end

  assign sig = sig_q;

  a_r9_sig_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !upd) |=> $stable(sig_q));
  a_r6_sig_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sig_q == '0));
endmodule

// File: rtl/bist_stim.sv
module bist_stim
  import bist_pkg::*;
#(
  parameter int LW  = LFSR_W,
  parameter int TAP = LFSR_TAP
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  input  logic [1:0]          mode_in,
  input  logic [SAMPLE_W-1:0] ext_i,
  input  logic [SAMPLE_W-1:0] ext_q,
  output logic [SAMPLE_W-1:0] stim_i,
  output logic [SAMPLE_W-1:0] stim_q
);
  localparam int SW = SAMPLE_W;
  localparam int PW = PHASE_W;
  localparam logic [PW-1:0] QUARTER = PW'(1 << (PW - 2));

  logic [1:0]    mode_q;
  logic [LW-1:0] lfsr_q, lfsr_d;
  logic [PW-1:0] ph_q, ph_d;
  logic          gen_en;

  function automatic logic [SW-1:0] qtr_mag(input logic [4:0] k);
    case (k)
      5'd0:  qtr_mag = 16'd0;
      5'd1:  qtr_mag = 16'd3212;
      5'd2:  qtr_mag = 16'd6393;
      5'd3:  qtr_mag = 16'd9512;
      5'd4:  qtr_mag = 16'd12539;
      5'd5:  qtr_mag = 16'd15446;
      5'd6:  qtr_mag = 16'd18204;
      5'd7:  qtr_mag = 16'd20787;
      5'd8:  qtr_mag = 16'd23170;
      5'd9:  qtr_mag = 16'd25329;
      5'd10: qtr_mag = 16'd27245;
      5'd11: qtr_mag = 16'd28898;
      5'd12: qtr_mag = 16'd30273;
      5'd13: qtr_mag = 16'd31356;
      5'd14: qtr_mag = 16'd32137;
      5'd15: qtr_mag = 16'd32609;
      default: qtr_mag = 16'd32767;
    endcase
  endfunction

  function automatic logic [SW-1:0] sine_at(input logic [PW-1:0] p);
    logic [4:0]    k;
    logic [SW-1:0] m;
    k = p[4] ? (5'd16 - {1'b0, p[3:0]}) : {1'b0, p[3:0]};
    m = qtr_mag(k);
    sine_at = p[5] ? (~m + 1'b1) : m;
  endfunction

  assign gen_en = load | step;

  always_comb begin
    lfsr_d = lfsr_q;
    ph_d   = ph_q;
    if (load) begin
      lfsr_d = '1;
      ph_d   = '0;
    end else if (step) begin
      lfsr_d = {lfsr_q[LW-2:0], lfsr_q[LW-1] ^ lfsr_q[TAP-1]};
      ph_d   = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= '1;
      ph_q   <= '0;
    end else if (gen_en) begin
      lfsr_q <= lfsr_d;
      ph_q   <= ph_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mode_q <= '0;
    else if (load) mode_q <= mode_in;
  end

  always_comb begin
    stim_i = '0;
    stim_q = '0;
    if (step) begin
      if (mode_q[1]) begin
        stim_i = lfsr_q[SW-1:0];
        stim_q = lfsr_q[LW-1:LW-SW];
      end else if (mode_q[0]) begin
        stim_i = sine_at(ph_q);
        stim_q = sine_at(ph_q + QUARTER);
      end else begin
        stim_i = ext_i;
        stim_q = ext_q;
      end
    end
  end

  a_r3_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (lfsr_q != '0));
  a_r4_phase_adv: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (ph_q == $past(ph_q) + 1'b1));
  a_r3_seed_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (lfsr_q == '1 && ph_q == '0));
endmodule

// File: rtl/chan_sigbist.sv
module chan_sigbist
  import bist_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep_in,
  input  logic                arm_in,
  input  logic                sync_in,
  input  logic [COUNT_W-1:0]  run_len,
  input  logic [1:0]          mode_sel,
  input  logic [SAMPLE_W-1:0] ext_i,
  input  logic [SAMPLE_W-1:0] ext_q,
  output logic [SAMPLE_W-1:0] stim_i,
  output logic [SAMPLE_W-1:0] stim_q,
  input  logic                chan_valid,
  input  logic [SAMPLE_W-1:0] chan_i,
  input  logic [SAMPLE_W-1:0] chan_q,
  output logic [SAMPLE_W-1:0] sig_i,
  output logic [SAMPLE_W-1:0] sig_q,
  output logic                busy,
  output logic                done
);
  logic [1:0] rs_q;
  logic       rst_l;
  logic       arm_ok, running, upd;

  logic [LANES-1:0][SAMPLE_W-1:0] lane_in, lane_sig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_l = rs_q[1];

  assign arm_ok = arm_in & sleep_in;

  bist_ctrl #(.CW(COUNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_l), .arm_ok(arm_ok), .sync(sync_in),
    .valid(chan_valid), .cnt_init(run_len),
    .running(running), .done(done), .upd(upd)
  );

  bist_stim #(.LW(LFSR_W), .TAP(LFSR_TAP)) u_stim (
    .clk(clk), .rst_n(rst_l), .load(arm_ok), .step(running),
    .mode_in(mode_sel), .ext_i(ext_i), .ext_q(ext_q),
    .stim_i(stim_i), .stim_q(stim_q)
  );

  assign lane_in[0] = chan_i;
  assign lane_in[1] = chan_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bist_misr #(.W(SAMPLE_W), .POLY(SIG_POLY)) u_misr (
      .clk(clk), .rst_n(rst_l), .clr(arm_ok), .upd(upd),
      .din(lane_in[g]), .sig(lane_sig[g])
    );
  end

  assign sig_i = lane_sig[0];
  assign sig_q = lane_sig[1];
  assign busy  = running;

  a_r11_arm_wins: assert property (@(posedge clk) disable iff (!rst_l)
    arm_ok |=> (!busy && !done && sig_i == '0 && sig_q == '0));
endmodule

// File: tb/sim_chan_sigbist.sv
module sim_chan_sigbist;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sleep_in, arm_in, sync_in;
  logic [19:0] run_len;
  logic [1:0]  mode_sel;
  logic [15:0] ext_i, ext_q;
  logic [15:0] stim_i, stim_q;
  logic        chan_valid;
  logic [15:0] chan_i, chan_q;
  logic [15:0] sig_i, sig_q;
  logic        busy, done;
  logic        vld_drive;

  int n_chk = 0;
  int n_fail = 0;
  int wd = 0;
  int cyc = 0;
  int vmod = 3;

  always #5 clk = ~clk;

  chan_sigbist u0 (
    .clk(clk), .rst_n(rst_n), .sleep_in(sleep_in), .arm_in(arm_in),
    .sync_in(sync_in), .run_len(run_len), .mode_sel(mode_sel),
    .ext_i(ext_i), .ext_q(ext_q), .stim_i(stim_i), .stim_q(stim_q),
    .chan_valid(chan_valid), .chan_i(chan_i), .chan_q(chan_q),
    .sig_i(sig_i), .sig_q(sig_q), .busy(busy), .done(done)
  );

  // placeholder channel: one register stage with a fixed transform
  always @(posedge clk) begin
    chan_valid <= vld_drive;
    chan_i     <= stim_i + 16'd5;
    chan_q     <= stim_q ^ 16'h00FF;
  end

  // reference model: 0 idle, 1 armed, 2 run, 3 done
  int          m_st;
  int          m_cnt;
  logic [22:0] m_lfsr;
  int          m_ph;
  logic [1:0]  m_mode;
  logic [15:0] m_si, m_sq;

  function automatic logic [15:0] sig_step(logic [15:0] s, logic [15:0] d);
    logic [15:0] r;
    r = s << 1;
    if (s[15]) r = r ^ 16'h100B;
    return r ^ d;
  endfunction

  function automatic logic [15:0] ref_sine(int p);
    real v;
    int  n;
    v = 32767.0 * $sin(2.0 * 3.14159265358979 * real'(p % 64) / 64.0);
    if (v >= 0.0) n = $rtoi(v + 0.5);
    else          n = -$rtoi(-v + 0.5);
    return 16'(n);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_lfsr = '1; m_ph = 0; m_mode = 0; m_si = 0; m_sq = 0;
    end else if (arm_in && sleep_in) begin
      m_st = 1; m_cnt = int'(run_len); m_lfsr = '1; m_ph = 0;
      m_mode = mode_sel; m_si = 0; m_sq = 0;
    end else if (m_st == 1) begin
      if (sync_in) m_st = (m_cnt == 0) ? 3 : 2;
    end else if (m_st == 2) begin
      if (chan_valid) begin
        m_si = sig_step(m_si, chan_i);
        m_sq = sig_step(m_sq, chan_q);
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) m_st = 3;
      end
      m_lfsr = {m_lfsr[21:0], m_lfsr[22] ^ m_lfsr[17]};
      m_ph = (m_ph + 1) % 64;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [15:0] ei, eq;
    string tag;
    ei = 0; eq = 0; tag = "R5 stim idle";
    if (m_st == 2) begin
      if (m_mode[1]) begin
        ei = m_lfsr[15:0]; eq = m_lfsr[22:7]; tag = "R3 prbs stim";
      end else if (m_mode[0]) begin
        ei = ref_sine(m_ph); eq = ref_sine(m_ph + 16); tag = "R4 sine stim";
      end else begin
        ei = ext_i; eq = ext_q; tag = "R2 ext stim";
      end
    end
    chk({tag, " I"}, 32'(stim_i), 32'(ei));
    chk({tag, " Q"}, 32'(stim_q), 32'(eq));
    chk("R8 sig_i", 32'(sig_i), 32'(m_si));
    chk("R8 sig_q", 32'(sig_q), 32'(m_sq));
    chk("R9 done", 32'(done), 32'(m_st == 3));
    chk("R12 busy", 32'(busy), 32'(m_st == 2));
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (rst_n) compare();
  endtask

  task automatic drive_cycles(int n);
    for (int k = 0; k < n; k++) begin
      tick();
      vld_drive = (cyc % vmod) != 0;
      ext_i = 16'(cyc * 977);
      ext_q = 16'(cyc * 31 + 7);
    end
  endtask

  task automatic arm_and_sync(logic [1:0] md, int len);
    sleep_in = 1'b1; mode_sel = md; run_len = 20'(len);
    arm_in = 1'b1;
    tick();
    arm_in = 1'b0; mode_sel = 2'b00; run_len = 20'd999;
    tick();
    sync_in = 1'b1;
    tick();
    sync_in = 1'b0;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      n_fail++;
      $display("FAIL R1 watchdog expired actual=%0d expected<50000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sleep_in = 0; arm_in = 0; sync_in = 0; run_len = 0;
    mode_sel = 0; ext_i = 0; ext_q = 0; vld_drive = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    // reset state (R5, R9, R12)
    chk("R5 reset stim_i", 32'(stim_i), 0);
    chk("R9 reset done", 32'(done), 0);
    chk("R12 reset busy", 32'(busy), 0);

    // R7: sync while idle does nothing
    sync_in = 1; tick(); sync_in = 0;
    chk("R7 idle sync ignored", 32'(busy), 0);

    // R3/R1: pseudorandom run with gapped valid, extra sync mid-run (R7)
    vmod = 3;
    arm_and_sync(2'b10, 37);
    drive_cycles(20);
    sync_in = 1; tick(); sync_in = 0;
    drive_cycles(60);
    chk("R1 prbs run finished", 32'(done), 1);

    // R9: valid after done is ignored, sync after done ignored
    sync_in = 1; drive_cycles(10); sync_in = 0;
    chk("R9 done holds", 32'(done), 1);

    // R6: arm without sleep ignored
    sleep_in = 0; arm_in = 1; tick(); arm_in = 0;
    chk("R6 arm without sleep", 32'(done), 1);

    // R4: sine run, valid nearly always
    vmod = 1000;
    arm_and_sync(2'b01, 70);
    drive_cycles(90);
    chk("R1 sine run finished", 32'(done), 1);

    // R2: external vectors
    vmod = 2;
    arm_and_sync(2'b00, 20);
    drive_cycles(50);
    chk("R1 ext run finished", 32'(done), 1);

    // R2: both select bits set picks pseudorandom
    vmod = 4;
    arm_and_sync(2'b11, 25);
    drive_cycles(45);
    chk("R2 mode 11 finished", 32'(done), 1);

    // R10: zero length
    arm_and_sync(2'b10, 0);
    chk("R10 zero length done", 32'(done), 1);
    chk("R10 zero length sig", 32'(sig_i), 0);

    // R11: arm collides with the final counted sample
    vmod = 1000;
    arm_and_sync(2'b01, 4);
    for (int k = 0; k < 20; k++) begin
      tick();
      vld_drive = 1'b1;
      if (m_st == 2 && m_cnt == 1 && chan_valid) begin
        sleep_in = 1; arm_in = 1; run_len = 20'd3;
        tick();
        arm_in = 0;
        chk("R11 arm wins done", 32'(done), 0);
        chk("R11 arm wins sig_i", 32'(sig_i), 0);
        chk("R11 arm wins busy", 32'(busy), 0);
        break;
      end
    end
    sync_in = 1; tick(); sync_in = 0;
    drive_cycles(10);
    chk("R1 rerun finished", 32'(done), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule